// File: doc/BRIEF.md
# Vector Mask and Compress Unit

This block keeps the 64-bit mask register of a vector unit and carries out every operation that reads or writes it. A compare operation builds the mask from a stream of per-element equality results, and either keeps the result as it is or inverts it. Other operations set the mask to all ones, count its ones, or walk it to produce a compressed index sequence. That sequence lists, in ascending order, each set-bit position multiplied by a caller-supplied scale, and serves as the offset vector for a gather that touches only the selected elements.

The datapath reads a per-element write enable from the block. A masked vector operation still spends one cycle on every element, and the mask only decides whether that element's result is written back. Arithmetic units and the register file sit outside this block.

Top module: `vmask_unit`

## Requirements
- R1: Opcode 0 (compare-equal) starts a compare of length L = op_vlen. For each streamed element e < L, mask bit e becomes cmp_eq.
- R2: Opcode 1 (compare-not-equal) works as R1, except that mask bit e becomes the inverse of cmp_eq.
- R3: A compare clears every mask bit at or above L. A streamed element whose number is at or above L changes nothing. With L = 0 the mask becomes all zeros and done pulses right away.
- R4: Opcode 2 writes 1 into all 64 mask bits and pulses done.
- R5: Opcode 3 loads pop_count with the number of ones in the mask and pulses done.
- R6: Opcode 4 emits one idx_data value per cycle with idx_valid high. The value is the bit position times op_scale, and a value is emitted only for set mask bits, in ascending position order.
- R7: The number of values emitted by opcode 4 equals the mask's popcount. Done pulses only after the last value has been emitted, including when the mask is empty.
- R8: wr_en equals mask bit wr_elem while mask_en is 1, and is 1 while mask_en is 0.
- R9: op_valid is ignored while busy is high, so an operation issued during a compress leaves the mask unchanged.
- R10: After reset the mask is all ones, pop_count is 0, and busy and idx_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation (taken when not busy) |
| op_code | input | 3 | 0 cmp-eq, 1 cmp-ne, 2 set-all, 3 popcount, 4 compress |
| op_vlen | input | 7 | Vector length for compares (clamped to 64) |
| op_scale | input | 16 | Index scale for compress |
| cmp_valid | input | 1 | Compare result present |
| cmp_elem | input | 6 | Element number of the compare result |
| cmp_eq | input | 1 | Element-equality result |
| mask_en | input | 1 | Masked execution enabled |
| wr_elem | input | 6 | Element queried for write enable |
| wr_en | output | 1 | Per-element write enable |
| vmask | output | 64 | Current mask register |
| pop_count | output | 7 | Result of the last popcount |
| idx_valid | output | 1 | Compressed index present |
| idx_data | output | 16 | Compressed index value |
| busy | output | 1 | Compare or compress in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Compares run with a short length that has a sparse pattern, and with the full length and a dense inverted pattern. The short case shows the effect of length handling, clearing above the length, and a stray element outside the length. The full-length case exposes polarity errors. Compress runs on a sparse mask with scale 8, on a dense mask with scale 3 while a second operation is pushed into the busy window, on an empty mask, and on a full mask with scale 1. Together these runs separate ordering faults, scaling faults, a missing or extra emission, and a mishandled empty case.

// File: rtl/vmask_unit.sv
module vmask_unit #(
  parameter int MAXVL = 64,
  parameter int IDXW  = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             op_valid,
  input  logic [2:0]                       op_code,
  input  logic [$clog2(MAXVL+1)-1:0]       op_vlen,
  input  logic [IDXW-1:0]                  op_scale,
  input  logic                             cmp_valid,
  input  logic [$clog2(MAXVL)-1:0]         cmp_elem,
  input  logic                             cmp_eq,
  input  logic                             mask_en,
  input  logic [$clog2(MAXVL)-1:0]         wr_elem,
  output logic                             wr_en,
  output logic [MAXVL-1:0]                 vmask,
  output logic [$clog2(MAXVL+1)-1:0]       pop_count,
  output logic                             idx_valid,
  output logic [IDXW-1:0]                  idx_data,
  output logic                             busy,
  output logic                             done
);
  localparam int EW = $clog2(MAXVL);
  localparam int LW = $clog2(MAXVL + 1);
  localparam logic [LW-1:0] VLMAX = LW'(MAXVL);

  localparam logic [2:0] OP_EQ = 3'd0, OP_NE = 3'd1, OP_SET = 3'd2,
                         OP_POP = 3'd3, OP_CPR = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_CPR} st_t;

  st_t              state;
  logic [MAXVL-1:0] mask, pend, low;
  logic [LW-1:0]    vl_q, cnt, vl_in;
  logic [IDXW-1:0]  scale_q;
  logic [EW-1:0]    pos;
  logic             pol_ne, found, op_go;

  assign op_go = op_valid && (state == S_IDLE);
  assign vl_in = (op_vlen > VLMAX) ? VLMAX : op_vlen;

  always_comb begin
    for (int i = 0; i < MAXVL; i++) low[i] = (LW'(i) < vl_q);
  end

  always_comb begin
    pos = '0;
    found = 1'b0;
    for (int i = 0; i < MAXVL; i++)
      if (pend[i] && !found) begin
        pos = EW'(i);
        found = 1'b1;
      end
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < MAXVL; i++) cnt = cnt + LW'(mask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mask      <= '1;
      pend      <= '0;
      vl_q      <= '0;
      scale_q   <= '0;
      pol_ne    <= 1'b0;
      pop_count <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (op_go) begin
          case (op_code)
            OP_EQ, OP_NE: begin
              mask   <= '0;
              pol_ne <= (op_code == OP_NE);
              vl_q   <= vl_in;
              if (vl_in == '0) done  <= 1'b1;
              else             state <= S_CMP;
            end
            OP_SET: begin
              mask <= '1;
              done <= 1'b1;
            end
            OP_POP: begin
              pop_count <= cnt;
              done      <= 1'b1;
            end
            OP_CPR: begin
              pend    <= mask;
              scale_q <= op_scale;
              state   <= S_CPR;
            end
            default: ;
          endcase
        end
        S_CMP: if (cmp_valid && (LW'(cmp_elem) < vl_q)) begin
          mask[cmp_elem] <= cmp_eq ^ pol_ne;
          if (LW'(cmp_elem) == vl_q - 1'b1) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_CPR: begin
          if (pend == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            pend[pos] <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign vmask     = mask;
  assign busy      = (state != S_IDLE);
  assign idx_valid = (state == S_CPR) && (pend != '0);
  assign idx_data  = IDXW'(pos) * scale_q;
  assign wr_en     = mask_en ? mask[wr_elem] : 1'b1;

  AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CMP) |-> ((mask & ~low) == '0)); // R3

  AST_SETALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_go && op_code == OP_SET) |-> (&mask)); // R4

  AST_IDX_FROM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> mask[pos]); // R6

  AST_PEND_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CPR && $past(state == S_CPR)) |-> ((pend & ~$past(pend)) == '0)); // R6

  AST_DONE_AFTER_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !idx_valid); // R7

  AST_MASK_HELD_CPR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CPR) |=> $stable(mask)); // R9
endmodule

// File: tb/vmask_unit_bench.sv
module vmask_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [6:0]  op_vlen = '0;
  logic [15:0] op_scale = '0;
  logic        cmp_valid = 1'b0;
  logic [5:0]  cmp_elem = '0;
  logic        cmp_eq = 1'b0;
  logic        mask_en = 1'b0;
  logic [5:0]  wr_elem = '0;
  logic        wr_en, idx_valid, busy, done;
  logic [63:0] vmask;
  logic [6:0]  pop_count;
  logic [15:0] idx_data;

  int total = 0, bad = 0, emitted = 0;
  logic [63:0] mdl = '1;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  vmask_unit u_vmask_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_vlen(op_vlen), .op_scale(op_scale), .cmp_valid(cmp_valid),
    .cmp_elem(cmp_elem), .cmp_eq(cmp_eq), .mask_en(mask_en),
    .wr_elem(wr_elem), .wr_en(wr_en), .vmask(vmask), .pop_count(pop_count),
    .idx_valid(idx_valid), .idx_data(idx_data), .busy(busy), .done(done));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && idx_valid) begin
      emitted++;
      if (exp_q.size() == 0) chk("R6 extra index", 64'(idx_data), 64'hFFFF_FFFF);
      else chk("R6 index", 64'(idx_data), 64'(exp_q.pop_front()));
    end
  end

  task automatic issue(input logic [2:0] code, input int vl, input int sc);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_vlen = 7'(vl); op_scale = 16'(sc);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    chk({req, " done"}, 64'(done), 64'd1);
  endtask

  task automatic run_cmp(input bit ne, input int vl, input logic [63:0] res, input int junk, input string req);
    issue(ne ? 3'd1 : 3'd0, vl, 0);
    mdl = '0;
    for (int i = 0; i < vl; i++) mdl[i] = res[i] ^ ne;
    for (int i = 0; i < vl; i++) begin
      if (i == vl - 1 && junk >= 0) begin
        cmp_valid = 1'b1; cmp_elem = 6'(junk); cmp_eq = ~ne;
        @(negedge clk);
        cmp_valid = 1'b0;
        @(negedge clk);
      end
      cmp_valid = 1'b1; cmp_elem = 6'(i); cmp_eq = res[i];
      @(negedge clk);
    end
    cmp_valid = 1'b0;
    wait_done(req);
    @(negedge clk);
    chk({req, " mask"}, vmask, mdl);
  endtask

  task automatic run_pop(input string req);
    issue(3'd3, 0, 0);
    wait_done(req);
    chk(req, 64'(pop_count), 64'($countones(mdl)));
  endtask

  task automatic run_cpr(input int sc, input bit poke);
    int want = 0;
    exp_q.delete();
    emitted = 0;
    for (int i = 0; i < 64; i++)
      if (mdl[i]) begin exp_q.push_back(16'(i * sc)); want++; end
    issue(3'd4, 0, sc);
    if (poke) begin
      op_valid = 1'b1; op_code = 3'd2;
      @(negedge clk);
      op_valid = 1'b0;
    end
    wait_done("R7");
    chk("R7 count", 64'(emitted), 64'(want));
    chk("R7 leftover", 64'(exp_q.size()), 64'd0);
    if (poke) chk("R9 mask kept", vmask, mdl);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 mask", vmask, '1);
    chk("R10 pop", 64'(pop_count), 64'd0);
    chk("R10 busy", 64'(busy), 64'd0);
    chk("R10 idx", 64'(idx_valid), 64'd0);

    run_cmp(1'b0, 10, 64'h0000_0000_0000_02A5, 40, "R1 R3");
    run_pop("R5");
    run_cpr(8, 1'b0);

    mask_en = 1'b1;
    for (int i = 0; i < 64; i++) begin
      wr_elem = 6'(i); #1;
      chk("R8 masked", 64'(wr_en), 64'(mdl[i]));
    end
    mask_en = 1'b0;
    for (int i = 0; i < 64; i += 7) begin
      wr_elem = 6'(i); #1;
      chk("R8 unmasked", 64'(wr_en), 64'd1);
    end

    run_cmp(1'b1, 64, 64'hF0F0_1234_0000_FFFF, -1, "R2");
    run_pop("R5");
    run_cpr(3, 1'b1);

    run_cmp(1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF, -1, "R3");
    run_pop("R5");
    run_cpr(5, 1'b0);

    issue(3'd2, 0, 0);
    mdl = '1;
    wait_done("R4");
    chk("R4 mask", vmask, '1);
    run_pop("R5");
    run_cpr(1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule